// File: doc/BRIEF.md
# Masked Fast-OR Trigger Output

This block forms a fast trigger from a bank of per-channel hit inputs. It samples them on a fast clock and gives each channel its own one-shot stretcher. A hit that lasts only one sample still yields a pulse of a guaranteed minimum width. The stretched channels then pass through a per-channel mask. Their logical OR is registered onto a dedicated fast-OR output.

The same OR can take over a shared command output line. When wire-OR mode is enabled, the block asserts an output enable and drives the line with the fast-OR value. When the mode is off, the enable drops and the line carries ordinary command data, delayed by one register. The mask register is written a whole word at a time. A stretcher width of 4 cycles at a 3.125 ns sampling period gives a minimum pulse of 12.5 ns, which is above the 10 ns floor.

Top module: `fast_or_trigger`

## Requirements
- R1: `fast_or_o` is the registered OR of all unmasked stretched channels. A hit first sampled at clock edge k shows on `fast_or_o` after edge k+1.
- R2: A hit that is high for a single sample on an unmasked channel makes `fast_or_o` high for exactly STRETCH cycles (4 by default).
- R3: A hit held high for N samples, with N at least STRETCH, keeps `fast_or_o` high for exactly N cycles. Its end follows the fall of the hit.
- R4: A new rising edge on a channel that is still stretching reloads the full width. Two single-sample hits two cycles apart give 6 high cycles.
- R5: Mask bit c = 1 removes channel c from the OR. A write (`mask_wr_en` = 1, word on `mask_wr_data`) is used by the OR at the edge after the write edge.
- R6: With `wor_mode_en` = 1 at an edge, after that edge `cmd_oe_o` = 1 and `cmd_line_o` equals `fast_or_o`. `cmd_data_i` has no effect.
- R7: With `wor_mode_en` = 0 at an edge, after that edge `cmd_oe_o` = 0 and `cmd_line_o` equals the `cmd_data_i` sampled at that edge.
- R8: Synchronous reset clears all outputs and all stretchers, and sets every mask bit to 1. A hit after reset has no effect on the outputs until the mask is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | NUM_CH | Per-channel hit levels |
| mask_wr_en | input | 1 | Load the mask register |
| mask_wr_data | input | NUM_CH | New mask word, 1 = channel masked |
| wor_mode_en | input | 1 | Route the fast-OR onto the command line |
| cmd_data_i | input | 1 | Normal command data for the shared line |
| fast_or_o | output | 1 | Registered fast-OR trigger |
| cmd_line_o | output | 1 | Registered shared command line value |
| cmd_oe_o | output | 1 | Output enable for the shared line in wire-OR mode |

## Verification
A hit driven before edge k sets the channel stretcher at edge k and reaches `fast_or_o` at edge k+1. This gives a fixed latency of two edges from the input to the fast-OR result. A mask write or a mode or command-data change lands in the outputs one edge after it is applied. Inputs for each vector are driven on the falling edge, one rising edge is taken, and the outputs are compared at the next falling edge against the values hand-derived for that edge. Pulse widths, retrigger extension and mask timing therefore show as exact runs of high or low in consecutive vectors.

// File: rtl/fastor_pkg.sv
package fastor_pkg;
  localparam int unsigned DEF_CH      = 8;
  localparam int unsigned DEF_STRETCH = 4;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/fastor_oneshot.sv
module fastor_oneshot #(
  parameter int unsigned STRETCH = fastor_pkg::DEF_STRETCH
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  output logic pulse_o
);
  localparam int unsigned CW = fastor_pkg::cnt_bits(STRETCH);
  localparam logic [CW-1:0] RELOAD = CW'(STRETCH - 1);

  logic          hit_prev;
  logic [CW-1:0] cnt_q;
  logic          rise;

  assign rise = hit_i & ~hit_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_prev <= 1'b0;
      cnt_q    <= '0;
      pulse_o  <= 1'b0;
    end else begin
      hit_prev <= hit_i;
      if (rise) begin
        cnt_q   <= RELOAD;
        pulse_o <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q   <= cnt_q - 1'b1;
        pulse_o <= 1'b1;
      end else begin
        pulse_o <= hit_i;
      end
    end
  end

  // run-length tracker used only by the width property
  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)                          run_q <= '0;
    else if (!pulse_o)                run_q <= '0;
    else if (run_q != CW'(STRETCH))   run_q <= run_q + 1'b1;
  end

  // R2
  min_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_o) |-> (run_q == CW'(STRETCH)));

  // R3
  hold_while_hit_chk: assert property (@(posedge clk) disable iff (rst)
    hit_i |=> pulse_o);

  // R4
  retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !hit_prev) |=> (pulse_o && cnt_q == RELOAD));
endmodule

// File: rtl/fastor_mask_reg.sv
module fastor_mask_reg #(
  parameter int unsigned NUM_CH = fastor_pkg::DEF_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [NUM_CH-1:0] wr_data,
  output logic [NUM_CH-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)        mask_o <= '1;
    else if (wr_en) mask_o <= wr_data;
  end

  // R5
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (mask_o == $past(wr_data)));

  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_o));
endmodule

// File: rtl/fastor_combine.sv
module fastor_combine #(
  parameter int unsigned NUM_CH = fastor_pkg::DEF_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pulse_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              wor_mode_en,
  input  logic              cmd_data_i,
  output logic              fast_or_o,
  output logic              cmd_line_o,
  output logic              cmd_oe_o
);
  logic [NUM_CH-1:0] live;
  logic              any_live;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_gate
      assign live[c] = pulse_i[c] & ~mask_i[c];
    end
  endgenerate

  assign any_live = |live;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_or_o  <= 1'b0;
      cmd_line_o <= 1'b0;
      cmd_oe_o   <= 1'b0;
    end else begin
      fast_or_o  <= any_live;
      cmd_line_o <= wor_mode_en ? any_live : cmd_data_i;
      cmd_oe_o   <= wor_mode_en;
    end
  end

  // R6
  wor_drive_chk: assert property (@(posedge clk) disable iff (rst)
    wor_mode_en |=> (cmd_oe_o && (cmd_line_o == fast_or_o)));

  // R7
  cmd_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !wor_mode_en |=> (!cmd_oe_o && (cmd_line_o == $past(cmd_data_i))));
endmodule

// File: rtl/fast_or_trigger.sv
module fast_or_trigger #(
  parameter int unsigned NUM_CH  = fastor_pkg::DEF_CH,
  parameter int unsigned STRETCH = fastor_pkg::DEF_STRETCH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              mask_wr_en,
  input  logic [NUM_CH-1:0] mask_wr_data,
  input  logic              wor_mode_en,
  input  logic              cmd_data_i,
  output logic              fast_or_o,
  output logic              cmd_line_o,
  output logic              cmd_oe_o
);
  logic [NUM_CH-1:0] pulse;
  logic [NUM_CH-1:0] mask_q;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chan
      fastor_oneshot #(.STRETCH(STRETCH)) u_shot (
        .clk     (clk),
        .rst     (rst),
        .hit_i   (hit_i[c]),
        .pulse_o (pulse[c])
      );
    end
  endgenerate

  fastor_mask_reg #(.NUM_CH(NUM_CH)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mask_wr_en),
    .wr_data (mask_wr_data),
    .mask_o  (mask_q)
  );

  fastor_combine #(.NUM_CH(NUM_CH)) u_comb (
    .clk         (clk),
    .rst         (rst),
    .pulse_i     (pulse),
    .mask_i      (mask_q),
    .wor_mode_en (wor_mode_en),
    .cmd_data_i  (cmd_data_i),
    .fast_or_o   (fast_or_o),
    .cmd_line_o  (cmd_line_o),
    .cmd_oe_o    (cmd_oe_o)
  );

  // R1
  idle_after_mask_all_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |=> !fast_or_o);
endmodule

// File: tb/fast_or_trigger_tb_top.sv
module fast_or_trigger_tb_top;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] hit_i = '0;
  logic           mask_wr_en = 1'b0;
  logic [NCH-1:0] mask_wr_data = '0;
  logic           wor_mode_en = 1'b0;
  logic           cmd_data_i = 1'b0;
  logic           fast_or_o, cmd_line_o, cmd_oe_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fast_or_trigger dut_i (
    .clk(clk), .rst(rst), .hit_i(hit_i), .mask_wr_en(mask_wr_en),
    .mask_wr_data(mask_wr_data), .wor_mode_en(wor_mode_en),
    .cmd_data_i(cmd_data_i), .fast_or_o(fast_or_o),
    .cmd_line_o(cmd_line_o), .cmd_oe_o(cmd_oe_o)
  );

  typedef struct packed {
    logic [7:0] hit;
    logic       we;
    logic [7:0] md;
    logic       mode;
    logic       cmd;
    logic       e_or;
    logic       e_line;
    logic       e_oe;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VEC [NV] = '{
    '{8'h00,1'b1,8'hF0,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 0 unmask ch0-3
    '{8'h01,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 1 ch0 blip (R2)
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 2 R1 latency
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 5 fourth high cycle
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 6 R2 end
    '{8'h10,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 7 masked ch4 (R5)
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1},
    '{8'h02,1'b0,8'h00,1'b0,1'b1, 1'b0,1'b1,1'b0}, // 10 R7 cmd passes
    '{8'h00,1'b0,8'h00,1'b0,1'b0, 1'b1,1'b0,1'b0}, // 11 R7 or not on line
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 12 R6
    '{8'h00,1'b0,8'h00,1'b1,1'b1, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b1, 1'b0,1'b0,1'b1}, // 15 R6 cmd ignored
    '{8'h04,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 16 R3 hold 6
    '{8'h04,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h04,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h04,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h04,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h04,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 22 sixth high
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 23 R3 end
    '{8'h08,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 24 R4 first
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h08,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 26 R4 reload
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 30 sixth high
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 31 R4 end
    '{8'h10,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 32 ch4 still masked
    '{8'h00,1'b1,8'hE0,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 33 R5 write, not yet
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}, // 34 R5 now visible
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1},
    '{8'h01,1'b1,8'hFF,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 38 R5 mask all
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1},
    '{8'h03,1'b1,8'h00,1'b1,1'b0, 1'b0,1'b0,1'b1}, // 41 R1 two channels
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1},
    '{8'h00,1'b0,8'h00,1'b1,1'b0, 1'b1,1'b1,1'b1}
  };

  task automatic check(input string tag, input int idx, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s step %0d: actual %b expected %b", tag, idx, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: state right out of reset
    tick();
    check("R8 fast_or", 0, fast_or_o, 1'b0);
    check("R8 line",    0, cmd_line_o, 1'b0);
    check("R8 oe",      0, cmd_oe_o, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      hit_i        = VEC[i].hit;
      mask_wr_en   = VEC[i].we;
      mask_wr_data = VEC[i].md;
      wor_mode_en  = VEC[i].mode;
      cmd_data_i   = VEC[i].cmd;
      tick();
      check("R1/R2/R3/R4/R5 fast_or", i, fast_or_o, VEC[i].e_or);
      check("R6/R7 line", i, cmd_line_o, VEC[i].e_line);
      check("R6/R7 oe",   i, cmd_oe_o, VEC[i].e_oe);
    end
    hit_i = '0; mask_wr_en = 1'b0;

    // R8: reset in the middle of a stretch, mask currently all clear
    hit_i = 8'h01;
    tick();
    hit_i = 8'h00;
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    wor_mode_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R8 stretch cleared", 100 + k, fast_or_o, 1'b0);
    end
    // R8: every channel masked after reset
    hit_i = 8'h20;
    tick();
    hit_i = 8'h00;
    for (int k = 0; k < 5; k++) begin
      tick();
      check("R8 all masked", 110 + k, cmd_line_o, 1'b0);
    end
    mask_wr_en = 1'b1; mask_wr_data = 8'h00;
    tick();
    mask_wr_en = 1'b0;
    hit_i = 8'h20;
    tick();
    hit_i = 8'h00;
    check("R1 before latency", 120, fast_or_o, 1'b0);
    tick();
    check("R1 after unmask", 121, fast_or_o, 1'b1);
    check("R6 line follows", 122, cmd_line_o, 1'b1);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule